// File: doc/BRIEF.md
# SRAM Access Phase Sequencer

This block steps a banked static memory through the control phases of a single access. A read or a write request is taken while the sequencer is idle. The sequencer then moves through a fixed series of phases, one fast-clock cycle each:

- bitline precharge,
- wordline on,
- sense enable on,
- wordline off,
- output capture.

During these phases it drives a precharge pulse, a one-hot wordline vector, a sense-amplifier enable, a one-hot word select within the row, per-block read and write enables, and a capture strobe. A behavioural storage array stands in for the bitcells. Because of that array, the data path of a read can be followed phase by phase.

The array holds 64 kilobits as 2048 words of 32 bits, spread over 16 blocks. Each row of a block holds two words. The address is split three ways. The top four bits choose the block, through two 2-to-4 predecoders whose outputs are combined into a one-of-sixteen select. The next bit picks the word within the row. The lowest six bits choose the row. Only the addressed block sees an active enable; every other block stays in no-operation. The request is held in a register that clears itself once taken, so each access starts from idle.

Top module: `sram_phase_seq`

## Requirements
- R1: A request is taken only on a rising edge where `ready` is 1. `ready` then drops for exactly five cycles. Requests presented while `ready` is 0 are ignored and start no access.
- R2: The first cycle after a request is taken is a one-cycle precharge: `pchg` is 1 and every wordline is 0.
- R3: The address is split as follows: `addr[10:7]` is the block, `addr[6]` is the word within the row, and `addr[5:0]` is the row. From the wordline-on phase through the capture phase, exactly one bit of the block enables is 1, bit `addr[10:7]`. For a read this is in `blk_rd_en`, for a write in `blk_wr_en`. In the same phases `col_sel` equals `1 << addr[6]`.
- R4: In the wordline-on and sense-on phases, `wl` equals `1 << addr[5:0]`. In every other phase `wl` is zero.
- R5: On a read, `sae` rises in the cycle after the wordline rises. It stays high through the wordline-off and capture phases. It is low again in the cycle after `cap` pulses. `cap` is 1 only in the capture phase.
- R6: On a write, `sae` and `cap` stay 0 for the whole access.
- R7: When `req_rd` and `req_wr` are both 1 as the request is taken, the access is a write.
- R8: `rdata` keeps its value through idle cycles and through write accesses.
- R9: A read returns, on `rdata` in the cycle after the capture phase, the word most recently written to the same address. The two words of one row are kept apart.
- R10: After reset, `ready` is 1, `rdata` is 0, and all phase controls and enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast phase clock |
| rst | input | 1 | Synchronous active-high reset |
| req_rd | input | 1 | Read request |
| req_wr | input | 1 | Write request |
| addr | input | 11 | Word address |
| wdata | input | 32 | Write data |
| ready | output | 1 | Sequencer idle, request will be taken |
| pchg | output | 1 | Bitline precharge pulse |
| wl | output | 64 | One-hot row wordlines |
| sae | output | 1 | Sense-amplifier enable |
| cap | output | 1 | Output-register capture strobe |
| col_sel | output | 2 | One-hot word-in-row select |
| blk_rd_en | output | 16 | Per-block enabled read |
| blk_wr_en | output | 16 | Per-block enabled write |
| rdata | output | 32 | Registered read data |

## Verification
Two pairs of functions can fall in the same cycle.

The first pair is read and write. Both requests are raised on the same edge. The access is judged as a write: `blk_wr_en` must carry the block bit, `sae` must stay low in every phase, and a following read must return the new word.

The second pair is a running access and a new request. A write request is held high from the precharge phase to the capture phase of a read. That request must leave no trace: `ready` must stay high afterwards, and a read of the targeted address must return its old contents.

// File: rtl/sps_pkg.sv
package sps_pkg;

    localparam int DATA_W    = 32;
    localparam int ROW_BITS  = 6;
    localparam int WSEL_BITS = 1;
    localparam int BLK_BITS  = 4;
    localparam int ADDR_W    = BLK_BITS + WSEL_BITS + ROW_BITS;
    localparam int ROWS      = 1 << ROW_BITS;
    localparam int WORDS     = 1 << WSEL_BITS;
    localparam int BLOCKS    = 1 << BLK_BITS;
    localparam int DEPTH     = 1 << ADDR_W;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_PCHG,
        PH_WLON,
        PH_SAON,
        PH_WLOFF,
        PH_CAP
    } phase_t;

    typedef struct packed {
        logic [BLK_BITS-1:0]  blk;
        logic [WSEL_BITS-1:0] wsel;
        logic [ROW_BITS-1:0]  row;
    } addr_t;

    typedef struct packed {
        logic              is_wr;
        addr_t             a;
        logic [DATA_W-1:0] wd;
    } op_t;

    function automatic phase_t step_phase(phase_t p);
        case (p)
            PH_PCHG:  return PH_WLON;
            PH_WLON:  return PH_SAON;
            PH_SAON:  return PH_WLOFF;
            PH_WLOFF: return PH_CAP;
            default:  return PH_IDLE;
        endcase
    endfunction

    function automatic logic in_access(phase_t p);
        return (p == PH_WLON) || (p == PH_SAON) || (p == PH_WLOFF) || (p == PH_CAP);
    endfunction

endpackage

// File: rtl/sps_phase_ctrl.sv
module sps_phase_ctrl
    import sps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rd,
    input  logic              req_wr,
    input  addr_t             addr,
    input  logic [DATA_W-1:0] wdata,
    output phase_t            phase,
    output op_t               op
);
    logic   take;
    phase_t phase_nx;

    assign take = (phase == PH_IDLE) && (req_rd || req_wr);

    always_comb begin
        if (phase == PH_IDLE) phase_nx = take ? PH_PCHG : PH_IDLE;
        else                  phase_nx = step_phase(phase);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            op    <= '0;
        end else begin
            phase <= phase_nx;
            if (take) begin
                op.is_wr <= req_wr;   // write wins when both are raised
                op.a     <= addr;
                op.wd    <= wdata;
            end
        end
    end
endmodule

// File: rtl/sps_decode.sv
module sps_decode
    import sps_pkg::*;
(
    input  addr_t             a,
    input  logic              wl_en,
    input  logic              acc_en,
    output logic [ROWS-1:0]   wl,
    output logic [BLOCKS-1:0] blk_sel,
    output logic [WORDS-1:0]  col_sel
);
    localparam int LO_BITS = BLK_BITS / 2;
    localparam int HI_BITS = BLK_BITS - LO_BITS;
    localparam int LO_N    = 1 << LO_BITS;
    localparam int HI_N    = 1 << HI_BITS;

    logic [LO_N-1:0] pre_lo;
    logic [HI_N-1:0] pre_hi;

    // two block predecoders, combined into one-of-BLOCKS
    always_comb begin
        pre_lo = '0;
        pre_hi = '0;
        pre_lo[a.blk[LO_BITS-1:0]]        = acc_en;
        pre_hi[a.blk[BLK_BITS-1:LO_BITS]] = acc_en;
    end

    for (genvar h = 0; h < HI_N; h++) begin : g_hi
        for (genvar l = 0; l < LO_N; l++) begin : g_lo
            assign blk_sel[h*LO_N + l] = pre_hi[h] & pre_lo[l];
        end
    end

    // row decoder gated by the intermediate wordline
    for (genvar r = 0; r < ROWS; r++) begin : g_row
        assign wl[r] = wl_en && (a.row == ROW_BITS'(r));
    end

    for (genvar w = 0; w < WORDS; w++) begin : g_col
        assign col_sel[w] = acc_en && (a.wsel == WSEL_BITS'(w));
    end
endmodule

// File: rtl/sps_store.sv
module sps_store
    import sps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_t            phase,
    input  op_t               op,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] cells [DEPTH];
    logic [DATA_W-1:0] sense_q;

    always_ff @(posedge clk) begin
        if (phase == PH_WLON && op.is_wr) cells[op.a] <= op.wd;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sense_q <= '0;
            rdata   <= '0;
        end else begin
            if (phase == PH_SAON && !op.is_wr) sense_q <= cells[op.a];
            if (phase == PH_CAP  && !op.is_wr) rdata   <= sense_q;
        end
    end
endmodule

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
    import sps_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_rd,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              ready,
    output logic              pchg,
    output logic [ROWS-1:0]   wl,
    output logic              sae,
    output logic              cap,
    output logic [WORDS-1:0]  col_sel,
    output logic [BLOCKS-1:0] blk_rd_en,
    output logic [BLOCKS-1:0] blk_wr_en,
    output logic [DATA_W-1:0] rdata
);
    phase_t            phase;
    op_t               op;
    logic              wl_int;
    logic              acc;
    logic [BLOCKS-1:0] blk_sel;

    sps_phase_ctrl u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .req_rd (req_rd),
        .req_wr (req_wr),
        .addr   (addr_t'(addr)),
        .wdata  (wdata),
        .phase  (phase),
        .op     (op)
    );

    assign wl_int = (phase == PH_WLON) || (phase == PH_SAON);
    assign acc    = in_access(phase);

    sps_decode u_dec (
        .a       (op.a),
        .wl_en   (wl_int),
        .acc_en  (acc),
        .wl      (wl),
        .blk_sel (blk_sel),
        .col_sel (col_sel)
    );

    sps_store u_store (
        .clk   (clk),
        .rst   (rst),
        .phase (phase),
        .op    (op),
        .rdata (rdata)
    );

    assign ready     = (phase == PH_IDLE);
    assign pchg      = (phase == PH_PCHG);
    assign sae       = !op.is_wr && ((phase == PH_SAON) || (phase == PH_WLOFF) || (phase == PH_CAP));
    assign cap       = !op.is_wr && (phase == PH_CAP);
    assign blk_rd_en = op.is_wr ? '0 : blk_sel;
    assign blk_wr_en = op.is_wr ? blk_sel : '0;
endmodule

// File: rtl/sps_checker.sv
module sps_checker
    import sps_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_rd,
    input logic              req_wr,
    input logic              ready,
    input logic              pchg,
    input logic [ROWS-1:0]   wl,
    input logic              sae,
    input logic              cap,
    input logic [BLOCKS-1:0] blk_rd_en,
    input logic [BLOCKS-1:0] blk_wr_en,
    input logic [DATA_W-1:0] rdata
);
    a_r4_wl_onehot: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wl));

    a_r2_pchg_no_wl: assert property (@(posedge clk) disable iff (rst)
        pchg |-> (wl == '0));

    a_r1_take_to_pchg: assert property (@(posedge clk) disable iff (rst)
        (ready && (req_rd || req_wr)) |=> pchg);

    a_r3_one_block: assert property (@(posedge clk) disable iff (rst)
        $onehot0(blk_rd_en | blk_wr_en) && ((blk_rd_en == '0) || (blk_wr_en == '0)));

    a_r5_sae_after_wl: assert property (@(posedge clk) disable iff (rst)
        $rose(sae) |-> $past(wl != '0));

    a_r5_sae_off_after_cap: assert property (@(posedge clk) disable iff (rst)
        cap |=> (!sae && ready));

    a_r6_no_sense_on_write: assert property (@(posedge clk) disable iff (rst)
        (blk_wr_en != '0) |-> (!sae && !cap));

    a_r8_idle_holds_rdata: assert property (@(posedge clk) disable iff (rst)
        (ready && !req_rd && !req_wr) |=> $stable(rdata));
endmodule

bind sram_phase_seq sps_checker u_sps_chk (
    .clk       (clk),
    .rst       (rst),
    .req_rd    (req_rd),
    .req_wr    (req_wr),
    .ready     (ready),
    .pchg      (pchg),
    .wl        (wl),
    .sae       (sae),
    .cap       (cap),
    .blk_rd_en (blk_rd_en),
    .blk_wr_en (blk_wr_en),
    .rdata     (rdata)
);

// File: tb/sram_phase_seq_tb_top.sv
`timescale 1ns/1ps
module sram_phase_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req_rd, req_wr;
    logic [10:0] addr;
    logic [31:0] wdata;
    logic        ready, pchg, sae, cap;
    logic [63:0] wl;
    logic [1:0]  col_sel;
    logic [15:0] blk_rd_en, blk_wr_en;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [2048];

    always #2.5 clk = ~clk;

    sram_phase_seq dut_i (
        .clk(clk), .rst(rst), .req_rd(req_rd), .req_wr(req_wr), .addr(addr), .wdata(wdata),
        .ready(ready), .pchg(pchg), .wl(wl), .sae(sae), .cap(cap), .col_sel(col_sel),
        .blk_rd_en(blk_rd_en), .blk_wr_en(blk_wr_en), .rdata(rdata)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // one access, checked phase by phase; samples taken at falling edges
    task automatic access(input bit rd, input bit wr, input logic [10:0] a, input logic [31:0] d);
        bit          is_wr   = wr;
        logic [31:0] prev    = rdata;
        logic [63:0] exp_wl  = 64'd1 << a[5:0];
        logic [15:0] exp_blk = 16'd1 << a[10:7];
        logic [1:0]  exp_col = 2'd1 << a[6];
        @(negedge clk);
        req_rd = rd; req_wr = wr; addr = a; wdata = d;
        @(negedge clk);
        req_rd = 0; req_wr = 0;
        chk(pchg === 1'b1 && wl === '0 && ready === 1'b0, "R2 precharge", {pchg, ready}, 2'b10);
        @(negedge clk);
        chk(wl === exp_wl, "R4 wordline on", wl, exp_wl);
        if (is_wr) chk(blk_wr_en === exp_blk && blk_rd_en === '0, "R3/R7 write block", blk_wr_en, exp_blk);
        else       chk(blk_rd_en === exp_blk && blk_wr_en === '0, "R3 read block", blk_rd_en, exp_blk);
        chk(col_sel === exp_col, "R3 word select", col_sel, exp_col);
        chk(sae === 1'b0, "R5 sense before wordline", sae, 0);
        @(negedge clk);
        chk(wl === exp_wl, "R4 wordline held", wl, exp_wl);
        chk(sae === !is_wr, is_wr ? "R6 sense on write" : "R5 sense on", sae, !is_wr);
        @(negedge clk);
        chk(wl === '0 && sae === !is_wr, is_wr ? "R6 wl off" : "R5 wl off", {wl != 0, sae}, {1'b0, !is_wr});
        @(negedge clk);
        chk(cap === !is_wr && sae === !is_wr && ready === 1'b0, is_wr ? "R6 capture" : "R5 capture",
            {cap, sae}, {!is_wr, !is_wr});
        @(negedge clk);
        chk(ready === 1'b1 && sae === 1'b0 && blk_rd_en === '0 && blk_wr_en === '0, "R1 five busy cycles",
            {ready, sae}, 2'b10);
        if (is_wr) begin
            model[a] = d;
            chk(rdata === prev, "R8 write keeps rdata", rdata, prev);
        end else begin
            chk(rdata === model[a], "R9 read data", rdata, model[a]);
        end
    endtask

    task automatic t_reset();
        chk(ready === 1'b1 && pchg === 1'b0 && wl === '0 && sae === 1'b0 && cap === 1'b0,
            "R10 reset controls", {ready, pchg, sae, cap}, 4'b1000);
        chk(rdata === '0 && blk_rd_en === '0 && blk_wr_en === '0 && col_sel === '0,
            "R10 reset data", rdata, 0);
    endtask

    task automatic t_write_read();
        access(0, 1, 11'h000, 32'hA5A5_0001);
        access(1, 0, 11'h000, 0);
        access(0, 1, 11'h7FF, 32'hDEAD_BEEF);
        access(1, 0, 11'h7FF, 0);
    endtask

    task automatic t_row_words(); // R9: two words of one row
        access(0, 1, {4'd5, 1'b0, 6'd17}, 32'h1111_2222);
        access(0, 1, {4'd5, 1'b1, 6'd17}, 32'h3333_4444);
        access(1, 0, {4'd5, 1'b0, 6'd17}, 0);
        access(1, 0, {4'd5, 1'b1, 6'd17}, 0);
        access(1, 0, {4'd10, 1'b1, 6'd42}, 0);
    endtask

    task automatic t_both_requests(); // R7
        access(1, 1, {4'd9, 1'b1, 6'd3}, 32'hCAFE_F00D);
        access(1, 0, {4'd9, 1'b1, 6'd3}, 0);
    endtask

    task automatic t_busy_ignored(); // R1
        logic [10:0] other = {4'd2, 1'b0, 6'd9};
        @(negedge clk);
        req_rd = 1; addr = 11'h000;
        @(negedge clk);
        req_rd = 0; req_wr = 1; addr = other; wdata = 32'hBAD0_BAD0;
        repeat (4) @(negedge clk);
        req_wr = 0;
        @(negedge clk);
        chk(ready === 1'b1 && rdata === model[11'h000], "R1 read during busy", rdata, model[11'h000]);
        @(negedge clk);
        chk(ready === 1'b1 && pchg === 1'b0, "R1 busy request dropped", {ready, pchg}, 2'b10);
        access(1, 0, other, 0);
    endtask

    task automatic t_idle_hold(); // R8
        logic [31:0] held = rdata;
        repeat (6) @(negedge clk);
        chk(rdata === held && ready === 1'b1, "R8 idle holds rdata", rdata, held);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        for (int i = 0; i < 2048; i++) model[i] = 32'h0;
        rst = 1; req_rd = 0; req_wr = 0; addr = '0; wdata = '0;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        t_reset();
        // seed the cells used by reads of untouched addresses
        access(0, 1, {4'd10, 1'b1, 6'd42}, 32'h0);
        access(0, 1, {4'd2, 1'b0, 6'd9}, 32'h0F0F_0F0F);
        t_write_read();
        t_row_words();
        t_both_requests();
        t_busy_ignored();
        t_idle_hold();
        finish_run();
    end
endmodule